// File: doc/BRIEF.md
# Dual-channel disk access decoder

This block sits between a host programmed-I/O port and up to four attached drives arranged as two channels of two drives each. Every access carries an address, a size code, a direction and write data. The block matches the address against five address windows, each with its own base register. The windows are the command window and the control window of channel 0, the same pair for channel 1, and one bus-master register window. From the match it classifies the access, computes the offset inside the matched window, and either steers the access to one of four drive ports or hands it to the bus-master register file. It keeps one device-select bit per channel. It learns that bit by watching host writes to the select register, so later accesses reach drive `2*channel + dev` without asking the drive.

A master I/O-enable input gates everything. While it is low, requests do nothing. Addresses outside every window and illegal sizes produce one-cycle error pulses instead of accesses. Window bases are loaded through a small configuration port and reset to zero. Window spans are parameters.

The result is held in a five-state output FSM. The states are `ST_IDLE`, `ST_DRIVE`, `ST_MASTER`, `ST_NOWIN` and `ST_BADSZ`. On every clock the FSM leaves whatever state it is in and takes the state picked by that cycle's request:
- no request, or I/O disabled: go to `ST_IDLE`
- no window matched: go to `ST_NOWIN`
- illegal size: go to `ST_BADSZ`
- bus-master window matched: go to `ST_MASTER`
- otherwise: go to `ST_DRIVE`

Each non-idle state lasts exactly one cycle unless another request follows.

Top module: `disk_pio_decoder`

## Requirements
- R1: An access hits window w when base_w <= addr < base_w + span_w. The reported offset is addr - base_w. Config index 0..4 selects channel-0 command, channel-0 control, channel-1 command, channel-1 control and bus-master. The default spans are 8, 4, 8, 4 and 16.
- R2: When several windows match, the lowest config index wins.
- R3: A bus-master hit raises `bm_valid` and no drive access. `bm_chan` is 0 when the offset is below 8 and 1 otherwise.
- R4: A legal write at offset 6 of a command window stores data bit 4 as that channel's device-select bit. Writes to a control window, reads, and other offsets leave the bit unchanged.
- R5: A command or control access is issued with drive index 2*channel + dev. A select write is steered by the value it is writing.
- R6: While `io_en` is 0, a request produces no output of any kind and changes no device-select bit.
- R7: Size code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is reserved. Code 2 to a command or control window, or code 3 to any window, gives an `err_size` pulse and no access.
- R8: `acc_byte` is 1 exactly when the size code is 0. `acc_cmd` is 1 exactly when a command window was hit.
- R9: An address matching no window gives a one-cycle `err_addr` pulse and no access.
- R10: After reset both device-select bits and all bases are 0 and every valid and error output is 0.
- R11: Each request's outcome appears on the outputs one cycle after the request is presented and lasts one cycle. At most one of `drv_valid`, `bm_valid`, `err_addr` and `err_size` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Master I/O decode enable |
| cfg_we | input | 1 | Load a window base |
| cfg_idx | input | 3 | Window selected for the load (0..4) |
| cfg_base | input | AW | Base value to load |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_size | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:reserved) |
| req_wdata | input | DW | Write data |
| drv_valid | output | 1 | Drive access issued |
| drv_idx | output | 2 | Target drive 0..3 |
| bm_valid | output | 1 | Bus-master register access issued |
| bm_chan | output | 1 | Channel owning the bus-master access |
| acc_write | output | 1 | Direction of the issued access |
| acc_byte | output | 1 | Issued access is byte-wide |
| acc_cmd | output | 1 | Issued access targets a command window |
| acc_offset | output | AW | Offset inside the matched window |
| acc_wdata | output | DW | Write data of the issued access |
| err_addr | output | 1 | Pulse: address hit no window |
| err_size | output | 1 | Pulse: illegal size for the window |

## Verification
The decoder is first driven with every base still at zero. This shows whether the priority order resolves a pile-up of five overlapping windows, and whether the bus-master split still works when the window sits at address zero. After the bases are moved apart, addresses just inside and just outside each window edge separate a correct `<` bound from an inclusive one. Select writes to command and to control windows, with bit 4 set and clear, followed by plain reads, show whether the shadow bit is learned only from the right register and whether the write that sets it is steered by its own value. Requests with I/O disabled, reserved and 4-byte sizes, and back-to-back requests complete the set.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_MASTER,
        ST_NOWIN,
        ST_BADSZ
    } dcd_state_e;

    localparam int NWIN     = 5;
    localparam int WIN_BM   = 4;
    localparam logic [1:0] SZ_WORD4 = 2'd2;
    localparam logic [1:0] SZ_RSVD  = 2'd3;
    localparam logic [1:0] SZ_BYTE  = 2'd0;
endpackage

// File: rtl/dcd_window.sv
module dcd_window #(
    parameter int AW   = 16,
    parameter int SPAN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_base,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);
    logic [AW-1:0] base_q;
    logic [AW:0]   limit;

    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load)
            base_q <= load_base;
    end

    assign limit  = {1'b0, base_q} + (AW+1)'(SPAN);
    assign hit    = ({1'b0, addr} >= {1'b0, base_q}) && ({1'b0, addr} < limit);
    assign offset = addr - base_q;
endmodule

// File: rtl/dcd_prio.sv
module dcd_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] hits,
    output logic         any,
    output logic [2:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i])
                idx = 3'(i);
        end
    end
    assign any = |hits;
endmodule

// File: rtl/dcd_devsel.sv
module dcd_devsel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wr,
    input  logic       bit_in,
    output logic [1:0] dev_q,
    output logic [1:0] dev_nx
);
    always_comb begin
        dev_nx = dev_q;
        for (int c = 0; c < 2; c++) begin
            if (wr[c])
                dev_nx[c] = bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_q <= '0;
        else
            dev_q <= dev_nx;
    end

    // R4: shadow bits move only on a select write
    p_dev_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|wr) |-> $stable(dev_q));
    // R4: both channels are never written by one access
    p_one_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));
endmodule

// File: rtl/disk_pio_decoder.sv
module disk_pio_decoder
    import dcd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPAN  = 16,
    parameter int SEL_OFF  = 6,
    parameter int DEV_BIT  = 4,
    parameter int BM_SPLIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_idx,
    input  logic [AW-1:0] cfg_base,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    output logic          drv_valid,
    output logic [1:0]    drv_idx,
    output logic          bm_valid,
    output logic          bm_chan,
    output logic          acc_write,
    output logic          acc_byte,
    output logic          acc_cmd,
    output logic [AW-1:0] acc_offset,
    output logic [DW-1:0] acc_wdata,
    output logic          err_addr,
    output logic          err_size
);
    localparam int SPANS [NWIN] = '{CMD_SPAN, CTL_SPAN, CMD_SPAN, CTL_SPAN, BM_SPAN};

    logic [NWIN-1:0] hits;
    logic [AW-1:0]   woff [NWIN];
    logic            any_hit;
    logic [2:0]      win;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        dcd_window #(.AW(AW), .SPAN(SPANS[g])) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (cfg_we && (cfg_idx == 3'(g))),
            .load_base (cfg_base),
            .addr      (req_addr),
            .hit       (hits[g]),
            .offset    (woff[g])
        );
    end

    dcd_prio #(.N(NWIN)) u_prio (
        .hits (hits),
        .any  (any_hit),
        .idx  (win)
    );

    logic [AW-1:0] off;
    logic          is_bm, is_cmd, chan, size_bad, go, sel_wr;
    logic [1:0]    dev_q, dev_nx, sel_wr_vec;

    always_comb begin
        off      = woff[win];
        is_bm    = (win == 3'(WIN_BM));
        is_cmd   = !is_bm && !win[0];
        chan     = is_bm ? (off >= AW'(BM_SPLIT)) : win[1];
        size_bad = (req_size == SZ_RSVD) || (!is_bm && req_size == SZ_WORD4);
        go       = req_valid && io_en;
        sel_wr   = go && any_hit && !size_bad && is_cmd && req_write
                   && (off == AW'(SEL_OFF));
        sel_wr_vec = sel_wr ? (chan ? 2'b10 : 2'b01) : 2'b00;
    end

    dcd_devsel u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sel_wr_vec),
        .bit_in (req_wdata[DEV_BIT]),
        .dev_q  (dev_q),
        .dev_nx (dev_nx)
    );

    dcd_state_e state_q, state_d;
    logic [AW-1:0] off_q;
    logic [DW-1:0] wdata_q;
    logic [1:0]    idx_q;
    logic          chan_q, write_q, byte_q, cmd_q;

    always_comb begin
        if (!go)
            state_d = ST_IDLE;
        else if (!any_hit)
            state_d = ST_NOWIN;
        else if (size_bad)
            state_d = ST_BADSZ;
        else if (is_bm)
            state_d = ST_MASTER;
        else
            state_d = ST_DRIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
            chan_q  <= 1'b0;
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            cmd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go) begin
                off_q   <= off;
                wdata_q <= req_wdata;
                idx_q   <= {chan, dev_nx[chan]};
                chan_q  <= chan;
                write_q <= req_write;
                byte_q  <= (req_size == SZ_BYTE);
                cmd_q   <= is_cmd;
            end
        end
    end

    always_comb begin
        drv_valid  = 1'b0;
        drv_idx    = '0;
        bm_valid   = 1'b0;
        bm_chan    = 1'b0;
        acc_write  = 1'b0;
        acc_byte   = 1'b0;
        acc_cmd    = 1'b0;
        acc_offset = '0;
        acc_wdata  = '0;
        err_addr   = 1'b0;
        err_size   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRIVE: begin
                drv_valid  = 1'b1;
                drv_idx    = idx_q;
                acc_write  = write_q;
                acc_byte   = byte_q;
                acc_cmd    = cmd_q;
                acc_offset = off_q;
                acc_wdata  = wdata_q;
            end
            ST_MASTER: begin
                bm_valid   = 1'b1;
                bm_chan    = chan_q;
                acc_write  = write_q;
                acc_byte   = byte_q;
                acc_offset = off_q;
                acc_wdata  = wdata_q;
            end
            ST_NOWIN: err_addr = 1'b1;
            ST_BADSZ: err_size = 1'b1;
            default: ;
        endcase
    end

    // R11: one outcome at a time
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_valid, bm_valid, err_addr, err_size}));
    // R11: every outcome is caused by a request one cycle earlier
    p_caused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_valid || bm_valid || err_addr || err_size) |-> $past(req_valid));
    // R6: disabled decode yields nothing
    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_en) |-> !(drv_valid || bm_valid || err_addr || err_size));
    // R7: drive accesses never carry a 4-byte or reserved size
    p_drv_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid |-> ($past(req_size) < 2'd2));
endmodule

// File: tb/sim_disk_pio_decoder.sv
module sim_disk_pio_decoder;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          drv_valid, bm_valid, bm_chan, acc_write, acc_byte, acc_cmd;
    logic          err_addr, err_size;
    logic [1:0]    drv_idx;
    logic [AW-1:0] acc_offset;
    logic [DW-1:0] acc_wdata;

    always #4 clk = ~clk;

    disk_pio_decoder u0 (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .drv_valid(drv_valid), .drv_idx(drv_idx), .bm_valid(bm_valid),
        .bm_chan(bm_chan), .acc_write(acc_write), .acc_byte(acc_byte),
        .acc_cmd(acc_cmd), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .err_addr(err_addr), .err_size(err_size)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string tag = "R10";

    // behavioural reference state
    int  m_base [5];
    int  m_span [5] = '{8, 4, 8, 4, 16};
    bit  m_dev  [2];
    bit  e_drv, e_bm, e_bmc, e_wr, e_byte, e_cmd, e_ea, e_es;
    int  e_idx, e_off;
    logic [DW-1:0] e_wd;

    always @(posedge clk) begin
        int w;
        int o;
        int ch;
        bit bad;
        e_drv = 0; e_bm = 0; e_bmc = 0; e_wr = 0; e_byte = 0; e_cmd = 0;
        e_ea = 0; e_es = 0; e_idx = 0; e_off = 0; e_wd = '0;
        if (!rst_n) begin
            foreach (m_base[i]) m_base[i] = 0;
            m_dev[0] = 0; m_dev[1] = 0;
        end else begin
            if (req_valid && io_en) begin
                w = -1;
                for (int i = 4; i >= 0; i--)
                    if (int'(req_addr) >= m_base[i] && int'(req_addr) < m_base[i] + m_span[i])
                        w = i;
                if (w < 0) e_ea = 1;
                else begin
                    o = int'(req_addr) - m_base[w];
                    bad = (req_size == 3) || (w != 4 && req_size == 2);
                    ch = (w == 4) ? (o >= 8 ? 1 : 0) : w / 2;
                    if (bad) e_es = 1;
                    else begin
                        if (w == 0 || w == 2)
                            if (req_write && o == 6) m_dev[ch] = req_wdata[4];
                        e_wr = req_write; e_byte = (req_size == 0);
                        e_off = o; e_wd = req_wdata;
                        if (w == 4) begin e_bm = 1; e_bmc = ch[0]; end
                        else begin
                            e_drv = 1; e_cmd = (w % 2 == 0);
                            e_idx = ch * 2 + int'(m_dev[ch]);
                        end
                    end
                end
            end
            if (cfg_we && cfg_idx < 5) m_base[cfg_idx] = int'(cfg_base);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (drv_valid !== e_drv || bm_valid !== e_bm || err_addr !== e_ea ||
                err_size !== e_es ||
                (e_drv && (int'(drv_idx) != e_idx || acc_cmd !== e_cmd)) ||
                (e_bm && bm_chan !== e_bmc) ||
                ((e_drv || e_bm) && (acc_write !== e_wr || acc_byte !== e_byte ||
                  int'(acc_offset) != e_off || acc_wdata !== e_wd))) begin
                failures++;
                $display("FAIL %s: got drv=%0d idx=%0d bm=%0d ch=%0d ea=%0d es=%0d off=%0h byte=%0d cmd=%0d exp drv=%0d idx=%0d bm=%0d ch=%0d ea=%0d es=%0d off=%0h byte=%0d cmd=%0d",
                    tag, drv_valid, drv_idx, bm_valid, bm_chan, err_addr, err_size,
                    acc_offset, acc_byte, acc_cmd, e_drv, e_idx, e_bm, e_bmc, e_ea,
                    e_es, e_off, e_byte, e_cmd);
            end
        end
    end

    task automatic acc(input string t, input bit wr, input int addr,
                       input logic [1:0] sz, input logic [DW-1:0] d);
        @(negedge clk);
        tag = t;
        req_valid = 1; req_write = wr; req_addr = AW'(addr);
        req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic setbase(input int w, input int b);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(w); cfg_base = AW'(b);
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R10";
        rst_n = 1;
        @(negedge clk);
        io_en = 1;
        // all bases zero: priority pile-up
        acc("R2", 0, 3, 2'd0, 0);
        acc("R3", 0, 9, 2'd0, 0);
        acc("R3", 1, 4, 2'd2, 32'hA5);
        acc("R9", 0, 16, 2'd0, 0);
        setbase(0, 16'h01F0); setbase(1, 16'h03F4);
        setbase(2, 16'h0170); setbase(3, 16'h0374); setbase(4, 16'hC000);
        acc("R1", 0, 16'h01F0, 2'd1, 0);
        acc("R1", 0, 16'h01F7, 2'd0, 0);
        acc("R9", 0, 16'h01F8, 2'd0, 0);
        acc("R9", 0, 16'h01EF, 2'd0, 0);
        acc("R1", 1, 16'h03F7, 2'd0, 32'h11);
        acc("R9", 0, 16'h03F8, 2'd0, 0);
        acc("R3", 0, 16'hC007, 2'd2, 0);
        acc("R3", 1, 16'hC008, 2'd0, 32'h7);
        acc("R9", 0, 16'hC010, 2'd0, 0);
        acc("R5", 1, 16'h01F6, 2'd0, 32'h10);
        acc("R5", 0, 16'h01F0, 2'd1, 0);
        acc("R5", 0, 16'h0170, 2'd0, 0);
        acc("R4", 1, 16'h03F6, 2'd0, 32'h00);
        acc("R4", 0, 16'h01F2, 2'd0, 0);
        acc("R4", 1, 16'h0176, 2'd0, 32'h10);
        acc("R4", 0, 16'h0176, 2'd0, 0);
        acc("R4", 1, 16'h01F6, 2'd0, 32'hEF);
        acc("R5", 0, 16'h0177, 2'd1, 0);
        acc("R7", 0, 16'h01F0, 2'd2, 0);
        acc("R7", 1, 16'h0176, 2'd3, 32'h10);
        acc("R7", 0, 16'hC004, 2'd3, 0);
        acc("R8", 0, 16'h0375, 2'd0, 0);
        acc("R8", 1, 16'h0172, 2'd1, 32'h5A5A);
        io_en = 0;
        acc("R6", 1, 16'h0176, 2'd0, 32'h00);
        acc("R6", 0, 16'h7777, 2'd0, 0);
        io_en = 1;
        acc("R6", 0, 16'h0170, 2'd0, 0);
        // overlap: channel-1 control moved over channel-1 command
        setbase(3, 16'h0172);
        acc("R2", 0, 16'h0174, 2'd0, 0);
        acc("R2", 0, 16'h0179, 2'd0, 0);
        // back-to-back requests
        @(negedge clk);
        tag = "R11";
        req_valid = 1; req_write = 0; req_addr = 16'h01F1; req_size = 0;
        @(negedge clk);
        req_addr = 16'hC00A;
        @(negedge clk);
        req_addr = 16'h9000;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule